// File: doc/BRIEF.md
# Masked Interrupt Condition Unit

This block turns a 16-bit group of live status flags from a bus controller into interrupt conditions and a single level-sensitive interrupt line. Every clock it registers the status flags as the raw condition vector. A software-owned enable mask selects which of those conditions may raise the interrupt.

Software reaches the block through a small register-access port with four addresses. Each address means one thing on a read and another on a write. The enable mask can be replaced outright, or bits can be set with an OR or cleared with an AND, so a handler can change one source without a read-modify-write. Reading the OR address returns the raw conditions, and reading the AND address returns the conditions that pass the mask. The interrupt line is high whenever at least one enabled condition is set.

Top module: `irq_cond_unit`

## Requirements
- R1: While `rst_ni` is low, the mask and the raw condition register are held at zero, whatever arrives on the status and access inputs, and `irq_o` is low.
- R2: On each rising clock edge out of reset, the raw condition register captures `status_i`, with the reserved bit forced to zero. A read of address 1 returns this registered value. Bit order, MSB first: 15 invalid command, 14 local bus parity error, 13 back-end overrun, 12 back-end access error, 11 arbitration lost, 10 NACK received, 9 data request, 8 command complete, 7 stop error, 6 bus busy, 5 bus not busy, 4 reserved, 3 SCL high, 2 SCL low, 1 SDA high, 0 SDA low.
- R3: A write to address 0 replaces the mask with `acc_wdata_i`.
- R4: A write to address 1 ORs `acc_wdata_i` into the mask.
- R5: A write to address 2 ANDs `acc_wdata_i` into the mask.
- R6: A read of address 2 returns the registered raw condition ANDed with the current mask.
- R7: `irq_o` is high exactly when the raw condition ANDed with the mask is nonzero.
- R8: A read of address 0 returns the current mask.
- R9: Address 3 reads as zero, and a write to it leaves the mask unchanged. `acc_rdata_o` is zero in any cycle without a read access (`acc_en_i` high, `acc_we_i` low).
- R10: Reads at any address never change the mask.
- R11: A mask write takes effect in the cycle after its clock edge. From that cycle the new mask is visible on reads at addresses 0 and 2 and on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 16 | Live status flags from the bus controller |
| acc_en_i | input | 1 | Register access strobe |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 2 | 0 mask, 1 raw read / OR write, 2 masked read / AND write, 3 unused |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Read data, combinational from registered state |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 16-bit condition vector with the reserved position at bit 4. At this width, a free-running pseudo-random stream of status values and access mixes can hit every mask bit through all three write views. The same stream also drives the reserved bit high often, so the forced-zero path is exercised. Directed sequences come first. They cover the held-reset state, the one-cycle capture delay, set/OR/AND in turn, reads that must not disturb the mask, and the first cycle in which a fresh mask enable raises the interrupt.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  typedef enum logic [1:0] {
    ACC_MASK    = 2'd0,
    ACC_RAW_OR  = 2'd1,
    ACC_MSK_AND = 2'd2,
    ACC_NONE    = 2'd3
  } acc_addr_e;

  typedef enum logic [1:0] {
    MOP_HOLD = 2'd0,
    MOP_SET  = 2'd1,
    MOP_OR   = 2'd2,
    MOP_AND  = 2'd3
  } mask_op_e;

  // condition bit positions (MSB first)
  localparam int unsigned C_INV_CMD   = 15;
  localparam int unsigned C_PARITY    = 14;
  localparam int unsigned C_OVERRUN   = 13;
  localparam int unsigned C_ACCESS    = 12;
  localparam int unsigned C_ARB_LOST  = 11;
  localparam int unsigned C_NACK      = 10;
  localparam int unsigned C_DATA_REQ  = 9;
  localparam int unsigned C_CMD_DONE  = 8;
  localparam int unsigned C_STOP_ERR  = 7;
  localparam int unsigned C_BUSY      = 6;
  localparam int unsigned C_NOT_BUSY  = 5;
  localparam int unsigned C_RESERVED  = 4;
  localparam int unsigned C_SCL_HI    = 3;
  localparam int unsigned C_SCL_LO    = 2;
  localparam int unsigned C_SDA_HI    = 1;
  localparam int unsigned C_SDA_LO    = 0;

endpackage

// File: rtl/icu_mask_reg.sv
module icu_mask_reg
  import irq_cond_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mask_op_e     op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);

  logic [W-1:0] mask_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt;
    always_comb begin
      unique case (op_i)
        MOP_SET: nxt = wdata_i[i];
        MOP_OR:  nxt = mask_q[i] | wdata_i[i];
        MOP_AND: nxt = mask_q[i] & wdata_i[i];
        default: nxt = mask_q[i];
      endcase
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[i] <= 1'b0;
      else         mask_q[i] <= nxt;
    end
  end

  assign mask_o = mask_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MOP_SET |=> mask_q == $past(wdata_i));
  p_or_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MOP_OR |=> mask_q == ($past(mask_q) | $past(wdata_i)));
  p_and_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MOP_AND |=> mask_q == ($past(mask_q) & $past(wdata_i)));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MOP_HOLD |=> $stable(mask_q));

endmodule

// File: rtl/icu_cond_cap.sv
module icu_cond_cap #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   RSVD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o
);

  localparam logic [W-1:0] KEEP = ~RSVD;

  logic [W-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= status_i & KEEP;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> raw_q == ($past(status_i) & KEEP));
  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q & RSVD) == '0);

endmodule

// File: rtl/icu_read_mux.sv
module icu_read_mux
  import irq_cond_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         rd_i,
  input  acc_addr_e    addr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] masked_i,
  output logic [W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ACC_MASK:    rdata_o = mask_i;
        ACC_RAW_OR:  rdata_o = raw_i;
        ACC_MSK_AND: rdata_o = masked_i;
        default:     rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_cond_unit.sv
module irq_cond_unit
  import irq_cond_pkg::*;
#(
  parameter int unsigned  COND_W = 16,
  parameter int unsigned  RSVD_BIT = C_RESERVED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COND_W-1:0] status_i,
  input  logic              acc_en_i,
  input  logic              acc_we_i,
  input  logic [1:0]        acc_addr_i,
  input  logic [COND_W-1:0] acc_wdata_i,
  output logic [COND_W-1:0] acc_rdata_o,
  output logic              irq_o
);

  localparam logic [COND_W-1:0] RSVD_MASK = COND_W'(1) << RSVD_BIT;

  acc_addr_e         addr;
  mask_op_e          op;
  logic              rd;
  logic [COND_W-1:0] mask, raw, masked;

  assign addr = acc_addr_e'(acc_addr_i);
  assign rd   = acc_en_i & ~acc_we_i;

  always_comb begin
    op = MOP_HOLD;
    if (acc_en_i && acc_we_i) begin
      unique case (addr)
        ACC_MASK:    op = MOP_SET;
        ACC_RAW_OR:  op = MOP_OR;
        ACC_MSK_AND: op = MOP_AND;
        default:     op = MOP_HOLD;
      endcase
    end
  end

  icu_mask_reg #(.W(COND_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (acc_wdata_i),
    .mask_o  (mask)
  );

  icu_cond_cap #(.W(COND_W), .RSVD(RSVD_MASK)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .mask_i   (mask),
    .raw_o    (raw),
    .masked_o (masked)
  );

  icu_read_mux #(.W(COND_W)) u_rd (
    .rd_i     (rd),
    .addr_i   (addr),
    .mask_i   (mask),
    .raw_i    (raw),
    .masked_i (masked),
    .rdata_o  (acc_rdata_o)
  );

  assign irq_o = |masked;

  p_irq_needs_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask != '0) && (raw != '0));
  p_masked_subset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr == ACC_MSK_AND) |-> (acc_rdata_o & ~mask) == '0);
  p_rdata_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_rdata_o != '0) |-> rd && addr != ACC_NONE);
  p_unused_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_we_i && addr == ACC_NONE) |=> $stable(mask));

endmodule

// File: tb/tb_irq_cond_unit.sv
`timescale 1ns/1ps
module tb_irq_cond_unit;
  localparam int W = 16;
  localparam logic [15:0] RSV = 16'h0010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [15:0] status = '0;
  logic        en = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  irq_cond_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .status_i(status),
    .acc_en_i(en), .acc_we_i(we), .acc_addr_i(addr),
    .acc_wdata_i(wdata), .acc_rdata_o(rdata), .irq_o(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_mask = '0, m_raw = '0;
  logic [31:0] lfsr = 32'hACE1_2468;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rd();
    if (!(en && !we)) return 16'h0;
    case (addr)
      2'd0: return m_mask;
      2'd1: return m_raw;
      2'd2: return m_raw & m_mask;
      default: return 16'h0;
    endcase
  endfunction

  task automatic step(string tag, logic e, logic w, logic [1:0] a,
                      logic [15:0] d, logic [15:0] s);
    @(negedge clk);
    en = e; we = w; addr = a; wdata = d; status = s;
    #1;
    chk(tag, "rdata", rdata, exp_rd());
    chk(tag, "irq", {15'b0, irq}, {15'b0, |(m_raw & m_mask)});
    @(posedge clk);
    if (rst_n) begin
      if (e && w) begin
        case (a)
          2'd0: m_mask = d;
          2'd1: m_mask = m_mask | d;
          2'd2: m_mask = m_mask & d;
          default: ;
        endcase
      end
      m_raw = s & ~RSV;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    // R1: held reset ignores all activity
    step("R1", 1, 1, 2'd0, 16'hFFFF, 16'hFFFF);
    step("R1", 1, 1, 2'd1, 16'hFFFF, 16'hFFFF);
    step("R1", 1, 0, 2'd0, 16'h0000, 16'hFFFF);
    step("R1", 1, 0, 2'd1, 16'h0000, 16'hFFFF);
    @(negedge clk); rst_n = 1'b1;

    // R2: capture one cycle late, reserved bit dropped
    step("R2", 0, 0, 2'd0, 16'h0, 16'h8421);
    step("R2", 1, 0, 2'd1, 16'h0, 16'hFFFF);
    step("R2", 1, 0, 2'd1, 16'h0, 16'h0000);
    step("R2", 1, 0, 2'd1, 16'h0, 16'h0000);

    // R3 / R8: direct replace, read back
    step("R3", 1, 1, 2'd0, 16'h00F0, 16'h0000);
    step("R8", 1, 0, 2'd0, 16'h0000, 16'h0000);
    step("R3", 1, 1, 2'd0, 16'h0F0F, 16'h0000);
    step("R8", 1, 0, 2'd0, 16'h0000, 16'h0000);

    // R4: OR-set
    step("R4", 1, 1, 2'd1, 16'hF000, 16'h0000);
    step("R4", 1, 0, 2'd0, 16'h0000, 16'h0000);

    // R10: reads leave mask alone
    step("R10", 1, 0, 2'd1, 16'hFFFF, 16'h5555);
    step("R10", 1, 0, 2'd2, 16'h0000, 16'h5555);
    step("R10", 1, 0, 2'd3, 16'hFFFF, 16'h5555);
    step("R10", 1, 0, 2'd0, 16'h0000, 16'h0000);

    // R5: AND-clear
    step("R5", 1, 1, 2'd2, 16'h0FFF, 16'h0000);
    step("R5", 1, 0, 2'd0, 16'h0000, 16'h0000);

    // R6: masked read
    step("R6", 0, 0, 2'd0, 16'h0000, 16'h0101);
    step("R6", 1, 0, 2'd2, 16'h0000, 16'hF0F0);
    step("R6", 1, 0, 2'd2, 16'h0000, 16'hF0F0);

    // R7: irq off with masked-out sources and with no sources
    step("R7", 1, 1, 2'd0, 16'h0000, 16'hFFFF);
    step("R7", 0, 0, 2'd0, 16'h0000, 16'hFFFF);
    step("R7", 1, 1, 2'd0, 16'hFFFF, 16'h0000);
    step("R7", 0, 0, 2'd0, 16'h0000, 16'h0000);

    // R11: enable one live source, irq the next cycle
    step("R11", 1, 1, 2'd0, 16'h0000, 16'h0008);
    step("R11", 1, 1, 2'd0, 16'h0008, 16'h0008);
    step("R11", 1, 0, 2'd2, 16'h0000, 16'h0008);

    // R9: unused address
    step("R9", 1, 1, 2'd3, 16'hFFFF, 16'h0008);
    step("R9", 1, 0, 2'd0, 16'h0000, 16'h0008);
    step("R9", 1, 0, 2'd3, 16'h0000, 16'h0008);
    step("R9", 0, 0, 2'd1, 16'h0000, 16'h0008);

    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R2/R4/R5/R6/R7/R8", lfsr[0], lfsr[1] & lfsr[2], lfsr[4:3],
           lfsr[20:5] ^ lfsr[31:16], lfsr[31:16]);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule